// File: doc/BRIEF.md
# Diagnostic Failure Frame Transmitter

This block keeps an eight-bit failure word and sends it, one bit at a time, on a single open-drain diagnostic line. It has no clock of its own for the serial data. Each falling edge of the control PWM input reaches the block as a one-cycle strobe, and that strobe moves the frame on by one position. An edge index counter runs modulo 32 and picks the symbol for the current position: a low start marker, the eight failure bits, a high stop marker, and then an idle stretch in which the line is released.

The failure word is built from the plug flags (open-load and overcurrent), a module-failure flag and a battery-undervoltage flag. Overcurrent flags are held until reset. The word can change only between frames, so a frame never shows a mix of old and new data. Each symbol appears on the line a fixed number of clock cycles after its strobe.

Top module: `diag_frame_tx`

## Requirements
- R1: After reset, and until the first strobe takes effect, `diag_line` is 1 (released).
- R2: Edge index 0 sends a 0 start marker, and edge index 9 sends a 1 stop marker.
- R3: Edge indices 10 to 31 send 1 (line released, idle).
- R4: The edge index wraps from 31 to 0, so a new frame begins every 32 strobes.
- R5: A symbol appears on `diag_line` exactly `OUT_DELAY` clock cycles after the cycle in which its strobe is high. The line holds its previous value until then.
- R6: The first frame after reset carries an all-zero failure word, whatever the inputs are.
- R7: The failure word is loaded only when no frame is in progress (edge index 0 or 10 to 31, and only after the first frame). Input changes made during edge indices 1 to 9 show up no earlier than the next frame.
- R8: Edge indices 1 to 8 send word bits 1 to 8, bit 1 first, where bit n is `word[n-1]`. Bits 1 to 6 are plug 1 to 6 flags. Bit 7 is 0 when those flags mean open-load and 1 when they mean overcurrent. Bit 8 is `module_fail OR bat_uv`.
- R9: An overcurrent flag seen on any cycle is stored until reset. While any flag is stored, bits 1 to 6 are the stored overcurrent flags and bit 7 is 1.
- R10: While `bat_uv` is 1 and no overcurrent is stored, bits 7 and 8 are 1 and bits 1 to 6 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| edge_stb | input | 1 | One-cycle strobe for each control-input falling edge |
| ol_flag | input | NUM_PLUGS | Open-load flag for each plug |
| oc_flag | input | NUM_PLUGS | Overcurrent flag for each plug |
| module_fail | input | 1 | Any module-level failure |
| bat_uv | input | 1 | Battery undervoltage |
| diag_line | output | 1 | 0 = line driven low, 1 = line released high |

## Verification
The bench builds the block with `NUM_PLUGS` = 6, `EDGES_PER_FRAME` = 32 and `OUT_DELAY` = 3. Using 3 instead of the default moves the presentation delay, and the bench measures it one cycle before and exactly at the expected cycle. Six full frames run back to back. This covers the forced-zero first frame, the wrap from index 31 to 0, a change made inside a frame that must stay out of it, battery undervoltage masking the plug bits, and overcurrent flags that pile up across separate pulses and outlast their inputs.

// File: rtl/diag_pkg.sv
package diag_pkg;

    localparam int DEF_PLUGS  = 6;
    localparam int DEF_EDGES  = 32;
    localparam int DEF_DELAY  = 4;

    typedef enum logic [1:0] {
        SLOT_START,
        SLOT_DATA,
        SLOT_END,
        SLOT_IDLE
    } slot_e;

    typedef struct packed {
        logic valid;
        logic level;
    } bit_tok_t;

    // Maps an edge index to the frame slot it drives.
    function automatic slot_e slot_of(input int unsigned idx, input int unsigned data_bits);
        if (idx == 0)
            return SLOT_START;
        if (idx <= data_bits)
            return SLOT_DATA;
        if (idx == data_bits + 1)
            return SLOT_END;
        return SLOT_IDLE;
    endfunction

endpackage

// File: rtl/diag_fault_compose.sv
module diag_fault_compose
    import diag_pkg::*;
#(
    parameter int NUM_PLUGS = DEF_PLUGS,
    localparam int WORD_W   = NUM_PLUGS + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PLUGS-1:0] ol_flag,
    input  logic [NUM_PLUGS-1:0] oc_flag,
    input  logic                 module_fail,
    input  logic                 bat_uv,
    output logic [WORD_W-1:0]    word
);

    logic [NUM_PLUGS-1:0] oc_sticky;
    logic                 oc_any;

    always_ff @(posedge clk) begin
        if (rst)
            oc_sticky <= '0;
        else
            oc_sticky <= oc_sticky | oc_flag;
    end

    always_comb begin
        oc_any = |oc_sticky;
        word[WORD_W-1] = module_fail | bat_uv;
        if (oc_any) begin
            word[WORD_W-2]      = 1'b1;
            word[NUM_PLUGS-1:0] = oc_sticky;
        end else begin
            word[WORD_W-2]      = bat_uv;
            word[NUM_PLUGS-1:0] = bat_uv ? '0 : ol_flag;
        end
    end

    assert_oc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (|oc_sticky) |=> ((oc_sticky & $past(oc_sticky)) == $past(oc_sticky)));

    assert_oc_view_R9: assert property (@(posedge clk) disable iff (rst)
        (|oc_sticky) |-> (word[WORD_W-2] && (word[NUM_PLUGS-1:0] == oc_sticky)));

    assert_uv_view_R10: assert property (@(posedge clk) disable iff (rst)
        (bat_uv && !(|oc_sticky)) |-> (word[WORD_W-1:WORD_W-2] == 2'b11 && word[NUM_PLUGS-1:0] == '0));

endmodule

// File: rtl/diag_frame_seq.sv
module diag_frame_seq
    import diag_pkg::*;
#(
    parameter int NUM_PLUGS = DEF_PLUGS,
    parameter int EDGES     = DEF_EDGES,
    localparam int WORD_W   = NUM_PLUGS + 2,
    localparam int IDX_W    = $clog2(EDGES),
    localparam int POS_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb,
    input  logic [WORD_W-1:0] word_in,
    output bit_tok_t          tok
);

    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  idx_m1;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] fail_reg;
    logic              armed;
    logic              busy;
    logic              wr_en;
    logic              lvl;
    slot_e             slot;

    always_comb begin
        slot   = slot_of(int'(idx), WORD_W);
        busy   = (slot == SLOT_DATA) || (slot == SLOT_END);
        wr_en  = armed && !busy;
        idx_m1 = idx - 1'b1;
        pos    = idx_m1[POS_W-1:0];
        case (slot)
            SLOT_START: lvl = 1'b0;
            SLOT_DATA:  lvl = fail_reg[pos];
            default:    lvl = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            armed    <= 1'b0;
            fail_reg <= '0;
            tok      <= '0;
        end else begin
            tok.valid <= stb;
            if (stb) begin
                tok.level <= lvl;
                idx       <= (idx == IDX_W'(EDGES - 1)) ? '0 : idx + 1'b1;
                if (slot == SLOT_END)
                    armed <= 1'b1;
            end
            if (wr_en)
                fail_reg <= word_in;
        end
    end

    assert_start_low_R2: assert property (@(posedge clk) disable iff (rst)
        (stb && slot == SLOT_START) |=> (tok.valid && !tok.level));

    assert_idx_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (stb && idx == IDX_W'(EDGES - 1)) |=> (idx == '0));

    assert_clear_first_R6: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (fail_reg == '0));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(fail_reg));

endmodule

// File: rtl/diag_out_delay.sv
module diag_out_delay
    import diag_pkg::*;
#(
    parameter int DELAY = DEF_DELAY
) (
    input  logic     clk,
    input  logic     rst,
    input  bit_tok_t tok_in,
    output logic     line
);

    generate
        if (DELAY > 1) begin : g_pipe
            bit_tok_t pipe [DELAY-1];

            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DELAY - 1; i++)
                        pipe[i] <= '0;
                    line <= 1'b1;
                end else begin
                    pipe[0] <= tok_in;
                    for (int i = 1; i < DELAY - 1; i++)
                        pipe[i] <= pipe[i-1];
                    if (pipe[DELAY-2].valid)
                        line <= pipe[DELAY-2].level;
                end
            end

            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !pipe[DELAY-2].valid |=> $stable(line));
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst)
                    line <= 1'b1;
                else if (tok_in.valid)
                    line <= tok_in.level;
            end

            assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
                !tok_in.valid |=> $stable(line));
        end
    endgenerate

endmodule

// File: rtl/diag_frame_tx.sv
module diag_frame_tx
    import diag_pkg::*;
#(
    parameter int NUM_PLUGS       = DEF_PLUGS,
    parameter int EDGES_PER_FRAME = DEF_EDGES,
    parameter int OUT_DELAY       = DEF_DELAY
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 edge_stb,
    input  logic [NUM_PLUGS-1:0] ol_flag,
    input  logic [NUM_PLUGS-1:0] oc_flag,
    input  logic                 module_fail,
    input  logic                 bat_uv,
    output logic                 diag_line
);

    localparam int WORD_W = NUM_PLUGS + 2;

    logic [WORD_W-1:0] word;
    bit_tok_t          tok;

    diag_fault_compose #(.NUM_PLUGS(NUM_PLUGS)) i_compose (
        .clk         (clk),
        .rst         (rst),
        .ol_flag     (ol_flag),
        .oc_flag     (oc_flag),
        .module_fail (module_fail),
        .bat_uv      (bat_uv),
        .word        (word)
    );

    diag_frame_seq #(.NUM_PLUGS(NUM_PLUGS), .EDGES(EDGES_PER_FRAME)) i_seq (
        .clk     (clk),
        .rst     (rst),
        .stb     (edge_stb),
        .word_in (word),
        .tok     (tok)
    );

    diag_out_delay #(.DELAY(OUT_DELAY)) i_delay (
        .clk    (clk),
        .rst    (rst),
        .tok_in (tok),
        .line   (diag_line)
    );

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> diag_line);

endmodule

// File: tb/test_diag_frame_tx.sv
module test_diag_frame_tx;

    localparam int DLY = 3;

    typedef struct {
        int    due;
        bit    lvl;
        string tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       edge_stb = 1'b0;
    logic [5:0] ol_flag = '0;
    logic [5:0] oc_flag = '0;
    logic       module_fail = 1'b0;
    logic       bat_uv = 1'b0;
    logic       diag_line;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t q[$];
    bit    prev_exp = 1'b1;

    // reference model state
    int         idx_m = 0;
    bit         armed_m = 0;
    bit         wrapped_m = 0;
    logic [7:0] reg_m = '0;
    logic [5:0] oc_m = '0;
    string      data_tag = "R6";

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    diag_frame_tx #(.NUM_PLUGS(6), .EDGES_PER_FRAME(32), .OUT_DELAY(DLY)) i_diag_frame_tx (
        .clk         (clk),
        .rst         (rst),
        .edge_stb    (edge_stb),
        .ol_flag     (ol_flag),
        .oc_flag     (oc_flag),
        .module_fail (module_fail),
        .bat_uv      (bat_uv),
        .diag_line   (diag_line)
    );

    task automatic chk(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: diag_line=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] compose();
        if (|oc_m)
            return {module_fail | bat_uv, 1'b1, oc_m};
        return {module_fail | bat_uv, bat_uv, bat_uv ? 6'b0 : ol_flag};
    endfunction

    task automatic strobe();
        item_t it;
        @(negedge clk);
        if (!(idx_m >= 1 && idx_m <= 9) && armed_m)
            reg_m = compose();
        if (idx_m == 0) begin
            it.lvl = 1'b0;
            it.tag = wrapped_m ? "R4 start after wrap" : "R2 start";
        end else if (idx_m <= 8) begin
            it.lvl = reg_m[idx_m-1];
            it.tag = data_tag;
        end else if (idx_m == 9) begin
            it.lvl = 1'b1;
            it.tag = "R2 stop";
            armed_m = 1;
        end else begin
            it.lvl = 1'b1;
            it.tag = "R3 idle";
        end
        idx_m = (idx_m + 1) % 32;
        if (idx_m == 0)
            wrapped_m = 1;
        it.due = cyc + 1 + DLY;
        q.push_back(it);
        edge_stb = 1'b1;
        @(negedge clk);
        edge_stb = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_strobes(input int n);
        for (int i = 0; i < n; i++)
            strobe();
    endtask

    task automatic pulse_oc(input logic [5:0] v);
        @(negedge clk);
        oc_flag = v;
        oc_m = oc_m | v;
        repeat (3) @(negedge clk);
        oc_flag = '0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: scoreboard pop and compare
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                if (cyc == q[0].due - 1)
                    chk(diag_line, prev_exp, "R5 line held before delay");
                if (cyc == q[0].due) begin
                    chk(diag_line, q[0].lvl, q[0].tag);
                    prev_exp = q[0].lvl;
                    it = q.pop_front();
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: released after reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(diag_line, 1'b1, "R1 released after reset");
        end
        // R6: faults present before first frame are not sent in it
        ol_flag = 6'b000101;
        module_fail = 1'b1;
        repeat (2) @(negedge clk);
        data_tag = "R6";
        run_strobes(32);
        // R8: plain open-load encoding, with a change inside the frame
        data_tag = "R8";
        run_strobes(4);
        ol_flag = 6'b111000;
        module_fail = 1'b0;
        run_strobes(28);
        // R7: the change made mid-frame appears only now
        data_tag = "R7";
        run_strobes(32);
        // R10: battery undervoltage masks plug bits
        bat_uv = 1'b1;
        data_tag = "R10";
        run_strobes(32);
        // R9: overcurrent stored after the flag drops
        bat_uv = 1'b0;
        ol_flag = 6'b000001;
        pulse_oc(6'b010010);
        data_tag = "R9";
        run_strobes(32);
        // R9: more overcurrent accumulates, open-load ignored
        pulse_oc(6'b100000);
        ol_flag = 6'b001100;
        module_fail = 1'b1;
        run_strobes(32);
        repeat (DLY + 4) @(negedge clk);
        if (q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL R5: pending=%0d expected=0", q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule